// File: doc/BRIEF.md
# ECC Diagnostic Fault Capture Unit

This block stands in for the multi-bit error reporting path of a RAM controller, in the form that memory diagnostics exercise. It watches the RAM write and read strobes together with the physical address, the identity of the requester and a force-syndrome control bit. A write made while the force-syndrome bit is low marks that one address as poisoned. A later read of exactly that address produces a multi-bit error event.

On the event the unit loads a fault address register with the low bits of the poisoned address and a fault kind register with a fixed code. It sets a frozen flag and a multi-bit-error flag, pulses an interrupt request and, only when the processor issued the failing read, pulses an external memory fault abort. Direct memory access engines and other masters see the status and the interrupt but never the abort. While the frozen flag is set the fault registers keep the first captured fault. Software releases them with a clear strobe.

Top module: `ecc_fault_capture`

## Requirements
- R1: A cycle with `wr_stb` high and `syn_force` low arms the unit and records `addr` as the poisoned address.
- R2: A cycle with `rd_stb` high while armed and with `addr` equal to the poisoned address is an error event. The event disarms the unit, so a repeated read of that address raises no further event.
- R3: On an event taken while not frozen, `flt_addr` becomes the poisoned address masked to its low 18 bits. In the same event `flt_kind` becomes 4'b0011, where bit 0 marks a processor I/O access and bit 1 marks a bus access.
- R4: An event sets `stat_frozen` and `stat_mbe`. Both stay set until a cycle with `stat_clr` high. When an event and `stat_clr` fall in the same cycle, the event wins and both flags stay set.
- R5: While `stat_frozen` is set, a further event leaves `flt_addr` and `flt_kind` unchanged.
- R6: Every event drives `irq_mbe` high for exactly the one cycle after the edge that sampled the read strobe.
- R7: `abort_ext` pulses together with `irq_mbe` only when `req_id` is 2'b00 (processor) on the failing read. For requester codes 2'b01, 2'b10 and 2'b11 no abort is raised.
- R8: Writes made with `syn_force` high leave the armed state and the poisoned address unchanged. Reads of any other address, and reads while not armed, raise no event and change nothing.
- R9: A later qualifying write replaces the poisoned address. A read of the old address then raises no event.
- R10: When a write and a read fall in the same cycle, the read is compared against the state held before that cycle. A qualifying write in that cycle takes precedence over the disarm, so the unit stays armed with the new address.
- R11: Synchronous active-high `rst` clears the armed flag, the poisoned address, the fault registers, both status flags and both pulse outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | RAM write strobe |
| rd_stb | input | 1 | RAM read strobe |
| addr | input | 32 | Physical address of the access |
| req_id | input | 2 | Requester code, 2'b00 is the processor |
| syn_force | input | 1 | Force-syndrome control bit; high suppresses poisoning |
| stat_clr | input | 1 | Clears the frozen and multi-bit-error flags |
| flt_addr | output | 18 | Captured fault address |
| flt_kind | output | 4 | Captured fault kind code |
| stat_frozen | output | 1 | Fault registers frozen flag |
| stat_mbe | output | 1 | Multi-bit error flag |
| irq_mbe | output | 1 | Multi-bit error interrupt request pulse |
| abort_ext | output | 1 | External memory fault abort pulse |

## Verification
The bench targets these cases:
- A read of the poisoned address issued by a non-processor requester. A design that ignored the requester would abort there.
- A second event while frozen. A design without the freeze would overwrite the first captured address.
- A write and a matching read in the same cycle, and a clear that collides with an event. A design that got the precedence wrong would disarm, or would drop the flags.
- A replaced poisoned address, force-syndrome writes and mismatching reads. A design that kept stale state would raise false events or miss the real one.

// File: rtl/ecc_fault_pkg.sv
package ecc_fault_pkg;

    typedef enum logic [1:0] {
        REQ_CPU = 2'b00,
        REQ_DMA = 2'b01,
        REQ_IOM = 2'b10,
        REQ_AUX = 2'b11
    } req_e;

    localparam int          KIND_W         = 4;
    localparam logic [3:0]  KIND_CPU_IOBUS = 4'b0011;

    typedef struct packed {
        logic wr_en;
        logic rd_en;
        logic syn_force;
    } bus_op_t;

    typedef struct packed {
        logic hit;
        logic from_cpu;
    } fault_evt_t;

    function automatic logic is_cpu_req(input logic [1:0] id);
        return id == REQ_CPU;
    endfunction

    function automatic logic poisons(input bus_op_t op);
        return op.wr_en && !op.syn_force;
    endfunction

endpackage

// File: rtl/ecc_poison_tracker.sv
module ecc_poison_tracker
    import ecc_fault_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [ADDR_W-1:0] rec_addr
);

    logic armed_q;
    logic [ADDR_W-1:0] addr_q;
    logic arm;

    assign arm      = poisons(op);
    assign hit      = op.rd_en && armed_q && (addr == addr_q);
    assign rec_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            addr_q  <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            addr_q  <= addr;
        end else if (hit) begin
            armed_q <= 1'b0;
        end
    end

    p_arm_record_r1: assert property (@(posedge clk) disable iff (rst)
        arm |=> (armed_q && addr_q == $past(addr)));

    p_hit_disarms_r2: assert property (@(posedge clk) disable iff (rst)
        (hit && !arm) |=> !armed_q);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!arm && !hit) |=> ($stable(armed_q) && $stable(addr_q)));

    p_hit_needs_match_r8: assert property (@(posedge clk) disable iff (rst)
        hit |-> (op.rd_en && armed_q));

endmodule

// File: rtl/ecc_fault_regs.sv
module ecc_fault_regs
    import ecc_fault_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FADDR_W = 18
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hit,
    input  logic [ADDR_W-1:0]  rec_addr,
    input  logic               stat_clr,
    output logic [FADDR_W-1:0] flt_addr,
    output logic [KIND_W-1:0]  flt_kind,
    output logic               stat_frozen,
    output logic               stat_mbe
);

    logic load;
    assign load = hit && !stat_frozen;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_addr <= '0;
            flt_kind <= '0;
        end else if (load) begin
            flt_addr <= rec_addr[FADDR_W-1:0];
            flt_kind <= KIND_CPU_IOBUS;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_frozen <= 1'b0;
            stat_mbe    <= 1'b0;
        end else begin
            stat_frozen <= hit || (stat_frozen && !stat_clr);
            stat_mbe    <= hit || (stat_mbe && !stat_clr);
        end
    end

    p_event_sets_r4: assert property (@(posedge clk) disable iff (rst)
        hit |=> (stat_frozen && stat_mbe));

    p_flags_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (stat_frozen && !stat_clr) |=> stat_frozen);

    p_frozen_keeps_r5: assert property (@(posedge clk) disable iff (rst)
        stat_frozen |=> ($stable(flt_addr) && $stable(flt_kind)));

    p_kind_code_r3: assert property (@(posedge clk) disable iff (rst)
        (hit && !stat_frozen) |=> (flt_kind == KIND_CPU_IOBUS));

endmodule

// File: rtl/ecc_fault_pulse.sv
module ecc_fault_pulse
    import ecc_fault_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  fault_evt_t evt,
    output logic       irq_mbe,
    output logic       abort_ext
);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_mbe   <= 1'b0;
            abort_ext <= 1'b0;
        end else begin
            irq_mbe   <= evt.hit;
            abort_ext <= evt.hit && evt.from_cpu;
        end
    end

    p_irq_follows_r6: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> irq_mbe);

    p_abort_cpu_only_r7: assert property (@(posedge clk) disable iff (rst)
        (evt.hit && !evt.from_cpu) |=> !abort_ext);

    p_abort_with_irq_r7: assert property (@(posedge clk) disable iff (rst)
        abort_ext |-> irq_mbe);

endmodule

// File: rtl/ecc_fault_capture.sv
module ecc_fault_capture
    import ecc_fault_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FADDR_W = 18,
    parameter int REQ_W   = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  logic               rd_stb,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [REQ_W-1:0]   req_id,
    input  logic               syn_force,
    input  logic               stat_clr,
    output logic [FADDR_W-1:0] flt_addr,
    output logic [KIND_W-1:0]  flt_kind,
    output logic               stat_frozen,
    output logic               stat_mbe,
    output logic               irq_mbe,
    output logic               abort_ext
);

    bus_op_t           op;
    fault_evt_t        evt;
    logic              hit;
    logic [ADDR_W-1:0] rec_addr;

    assign op.wr_en     = wr_stb;
    assign op.rd_en     = rd_stb;
    assign op.syn_force = syn_force;

    assign evt.hit      = hit;
    assign evt.from_cpu = is_cpu_req(req_id[1:0]);

    ecc_poison_tracker #(.ADDR_W(ADDR_W)) u_track (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .addr     (addr),
        .hit      (hit),
        .rec_addr (rec_addr)
    );

    ecc_fault_regs #(.ADDR_W(ADDR_W), .FADDR_W(FADDR_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .hit         (hit),
        .rec_addr    (rec_addr),
        .stat_clr    (stat_clr),
        .flt_addr    (flt_addr),
        .flt_kind    (flt_kind),
        .stat_frozen (stat_frozen),
        .stat_mbe    (stat_mbe)
    );

    ecc_fault_pulse u_pulse (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .irq_mbe   (irq_mbe),
        .abort_ext (abort_ext)
    );

    p_reset_clears_r11: assert property (@(posedge clk)
        rst |=> (!irq_mbe && !abort_ext && !stat_frozen && !stat_mbe && flt_addr == '0));

endmodule

// File: tb/ecc_fault_capture_tb.sv
`timescale 1ns/1ps
module ecc_fault_capture_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_stb = 1'b0, rd_stb = 1'b0, syn_force = 1'b0, stat_clr = 1'b0;
    logic [31:0] addr = '0;
    logic [1:0]  req_id = '0;
    logic [17:0] flt_addr;
    logic [3:0]  flt_kind;
    logic        stat_frozen, stat_mbe, irq_mbe, abort_ext;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // reference model state
    logic        m_arm = 0;
    logic [31:0] m_addr = 0;
    logic [17:0] m_faddr = 0;
    logic [3:0]  m_kind = 0;
    logic        m_frz = 0, m_mbe = 0, m_irq = 0, m_abt = 0;

    always #10 clk = ~clk;

    ecc_fault_capture u_dut (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
        .req_id(req_id), .syn_force(syn_force), .stat_clr(stat_clr),
        .flt_addr(flt_addr), .flt_kind(flt_kind), .stat_frozen(stat_frozen),
        .stat_mbe(stat_mbe), .irq_mbe(irq_mbe), .abort_ext(abort_ext)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        chk(tag, "flt_addr", 32'(flt_addr), 32'(m_faddr));
        chk(tag, "flt_kind", 32'(flt_kind), 32'(m_kind));
        chk(tag, "stat_frozen", 32'(stat_frozen), 32'(m_frz));
        chk(tag, "stat_mbe", 32'(stat_mbe), 32'(m_mbe));
        chk(tag, "irq_mbe", 32'(irq_mbe), 32'(m_irq));
        chk(tag, "abort_ext", 32'(abort_ext), 32'(m_abt));
    endtask

    // one cycle: drive at negedge, model the edge, compare at next negedge
    task automatic step(input logic w, input logic r, input logic [31:0] a,
                        input logic [1:0] q, input logic f, input logic c, input string tag);
        logic hit;
        wr_stb = w; rd_stb = r; addr = a; req_id = q; syn_force = f; stat_clr = c;
        hit = r && m_arm && (a == m_addr);
        if (hit && !m_frz) begin
            m_faddr = m_addr[17:0];
            m_kind  = 4'b0011;
        end
        m_frz = hit || (m_frz && !c);
        m_mbe = hit || (m_mbe && !c);
        m_irq = hit;
        m_abt = hit && (q == 2'b00);
        if (w && !f) begin
            m_arm  = 1'b1;
            m_addr = a;
        end else if (hit) begin
            m_arm = 1'b0;
        end
        @(negedge clk);
        cmp_all(tag);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wr_stb = 1'b1; rd_stb = 1'b1; syn_force = 1'b0; addr = 32'h55; stat_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wr_stb = 1'b0; rd_stb = 1'b0;
        m_arm = 0; m_addr = 0; m_faddr = 0; m_kind = 0;
        m_frz = 0; m_mbe = 0; m_irq = 0; m_abt = 0;
        cmp_all("R11");
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R1, R2, R3: poison then read back by processor
        step(1, 0, 32'h0004_1238, 2'b00, 0, 0, "R1");
        step(0, 1, 32'h0004_1238, 2'b00, 0, 0, "R3");
        chk("R3", "flt_addr low 18 bits", 32'(flt_addr), 32'h0_1238);
        chk("R6", "irq pulse", 32'(irq_mbe), 32'd1);
        step(0, 0, 32'h0, 2'b00, 0, 0, "R6");
        chk("R6", "irq single cycle", 32'(irq_mbe), 32'd0);
        step(0, 1, 32'h0004_1238, 2'b00, 0, 0, "R2");
        chk("R2", "no repeat event", 32'(irq_mbe), 32'd0);

        // R4 clear
        step(0, 0, 32'h0, 2'b00, 0, 1, "R4");
        chk("R4", "frozen cleared", 32'(stat_frozen), 32'd0);

        // R8 force-syndrome write, mismatching read
        step(1, 0, 32'h0000_0100, 2'b00, 1, 0, "R8");
        step(0, 1, 32'h0000_0100, 2'b00, 0, 0, "R8");
        chk("R8", "force write no event", 32'(irq_mbe), 32'd0);
        step(1, 0, 32'h0000_0200, 2'b00, 0, 0, "R8");
        step(1, 0, 32'h0000_0300, 2'b01, 1, 0, "R8");
        step(0, 1, 32'h0000_0204, 2'b00, 0, 0, "R8");
        // R7 DMA read of poisoned address
        step(0, 1, 32'h0000_0200, 2'b01, 0, 0, "R7");
        chk("R7", "dma irq", 32'(irq_mbe), 32'd1);
        chk("R7", "dma no abort", 32'(abort_ext), 32'd0);

        // R5 second event while frozen
        step(1, 0, 32'h0003_FFFC, 2'b00, 0, 0, "R5");
        step(0, 1, 32'h0003_FFFC, 2'b10, 0, 0, "R5");
        chk("R5", "flt_addr kept", 32'(flt_addr), 32'h0_0200);
        // R4 clear colliding with event
        step(1, 0, 32'h0000_0400, 2'b00, 0, 0, "R4");
        step(0, 1, 32'h0000_0400, 2'b00, 0, 1, "R4");
        chk("R4", "event beats clear", 32'(stat_frozen), 32'd1);
        step(0, 0, 32'h0, 2'b00, 0, 1, "R4");

        // R9 replacement
        step(1, 0, 32'h0000_1000, 2'b00, 0, 0, "R9");
        step(1, 0, 32'h0000_2000, 2'b00, 0, 0, "R9");
        step(0, 1, 32'h0000_1000, 2'b00, 0, 0, "R9");
        chk("R9", "old address silent", 32'(irq_mbe), 32'd0);
        step(0, 1, 32'h0000_2000, 2'b00, 0, 0, "R9");
        chk("R9", "new address fires", 32'(abort_ext), 32'd1);
        step(0, 0, 32'h0, 2'b00, 0, 1, "R4");

        // R10 same-cycle write and read
        step(1, 0, 32'h0000_3000, 2'b00, 0, 0, "R10");
        step(1, 1, 32'h0000_3000, 2'b11, 0, 0, "R10");
        step(0, 1, 32'h0000_3000, 2'b00, 0, 0, "R10");
        chk("R10", "write kept armed", 32'(irq_mbe), 32'd1);

        // R11 mid-run reset
        step(1, 0, 32'h0000_4000, 2'b00, 0, 0, "R11");
        do_reset();
        step(0, 1, 32'h0000_4000, 2'b00, 0, 0, "R11");

        // random phase over a small address pool
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] pool [4];
            pool[0] = 32'h0000_0010; pool[1] = 32'h0001_0010;
            pool[2] = 32'hFFFC_0010; pool[3] = 32'h0000_0014;
            step(($urandom % 3) == 0, ($urandom % 2) == 0, pool[$urandom % 4],
                 2'($urandom % 4), ($urandom % 4) == 0, ($urandom % 8) == 0, "R8");
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule